// File: doc/BRIEF.md
# Interleaved SEC-DED Link Word Codec

This block guards words on a serial link with a Hamming code that corrects any single bit error and detects any double bit error in each word. The encoder turns every data word into a 22-bit codeword (16 data bits, five position check bits and one overall parity bit). It collects 16 codewords into a block and sends them out again as 16 line words whose bits are transposed. Two bits that sit next to each other on the serial line therefore always belong to different codewords.

The decoder takes 16 line words, undoes the transposition and checks each codeword. It corrects a single error, and it marks a codeword as uncorrectable when it finds two errors. A burst of up to 16 adjacent line bits touches each codeword at most once, so it is corrected. A burst of up to 32 adjacent bits touches each codeword at most twice, so it is always flagged.

Both directions are double-buffered. One block fills while the block before it drains on 16 consecutive cycles. The encode side and the decode side are independent and can be looped back through the serial line.

Top module: `hilv_codec`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `line_tx_valid_o` and `dec_valid_o` are low.
- R2: Codeword bit 0 makes the whole 22-bit codeword even parity. Bits 1 to 21 are Hamming positions. The check bits sit at positions 1, 2, 4, 8 and 16. The check bit at position 2^i gives even parity over every position whose index has bit i set. Data bit 0 goes to the lowest remaining position (3), and the other data bits follow upward in order.
- R3: Within a block, serial index n = w*22 + b refers to line word w (0..15) and bit b, with bit 0 sent first. That serial bit carries bit (n div 16) of codeword (n mod 16), and codewords are numbered in arrival order.
- R4: Suppose the 16th accepted input word of a block is sampled at clock edge e. Then line word m (0..15) is driven with `line_tx_valid_o` high right after edge e+1+m. Outside these windows `line_tx_valid_o` is low.
- R5: Cycles with `enc_valid_i` low are ignored. A block is formed from the next 16 valid words, whatever gaps lie between them.
- R6: Suppose the 16th received line word of a block is sampled at edge e. Then decoded word m is presented with `dec_valid_o` high right after edge e+2+m.
- R7: A single flipped bit in positions 1..21 is repaired. The word leaves with corrected=1 and uncorrectable=0.
- R8: Overall parity is odd and the syndrome is zero: only bit 0 is wrong. The data leaves unchanged with corrected=1.
- R9: Overall parity is even and the syndrome is nonzero. The word leaves with uncorrectable=1, corrected=0, and its data bits read without correction.
- R10: Any burst of 11 or fewer adjacent serial bits within one block decodes to the original 16 words.
- R11: For any burst of 31 or fewer adjacent serial bits, every decoded word is either the original data or marked uncorrectable.
- R12: Both flags are 0 for an error-free word and on every cycle where `dec_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Data word present for encoding |
| enc_data_i | input | 16 | Data word to protect |
| line_tx_valid_o | output | 1 | Interleaved line word valid |
| line_tx_word_o | output | 22 | Interleaved line word, bit 0 first on the line |
| line_rx_valid_i | input | 1 | Received line word present |
| line_rx_word_i | input | 22 | Received line word |
| dec_valid_o | output | 1 | Decoded word valid |
| dec_data_o | output | 16 | Decoded (corrected where possible) data |
| dec_corrected_o | output | 1 | A single error was repaired in this word |
| dec_uncorrectable_o | output | 1 | A double error was detected in this word |

## Verification
The bench keeps a behavioural model that numbers every rising edge after reset. When the model sees the 16th word of a block, it queues the expected encoded line words with due edges e+1 through e+16. When it sees the 16th received line word, it queues the expected decoded words with due edges e+2 through e+17. On each falling edge the outputs are compared with the head of each queue, and the valid signal must be low when nothing is due on that edge, so any early, late or extra output is caught. The line is looped back, and per-block error masks add bursts and separate bit flips. The decoded stream is also compared end-to-end against the data that was sent.

// File: rtl/hilv_pkg.sv
package hilv_pkg;

  // Number of Hamming position check bits needed to cover dw data bits.
  function automatic int pos_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Full codeword width: data, position checks, overall parity.
  function automatic int cw_bits(input int dw);
    return dw + pos_bits(dw) + 1;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // Hamming position that carries data bit i (skips powers of two).
  function automatic int data_slot(input int i);
    int cnt;
    cnt = 0;
    for (int p = 1; p < 64; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == i) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  typedef struct packed {
    logic corrected;
    logic uncorrectable;
  } ecc_flags_t;

endpackage

// File: rtl/hilv_encoder.sv
module hilv_encoder
  import hilv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]          data_i,
  output logic [cw_bits(DATA_W)-1:0] cw_o
);

  localparam int P  = pos_bits(DATA_W);
  localparam int HW = DATA_W + P;

  logic [HW:1] dpos;
  logic [HW:1] body;
  logic        acc;

  always_comb begin
    dpos = '0;
    for (int i = 0; i < DATA_W; i++) dpos[data_slot(i)] = data_i[i];
    body = dpos;
    acc  = 1'b0;
    for (int i = 0; i < P; i++) begin
      acc = 1'b0;
      for (int p = 1; p <= HW; p++) begin
        if (p[i] && !is_pow2(p)) acc = acc ^ dpos[p];
      end
      body[1 << i] = acc;
    end
  end

  // bit 0 closes even parity over the whole codeword
  assign cw_o = {body, ^body};

endmodule

// File: rtl/hilv_decoder.sv
module hilv_decoder
  import hilv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       valid_i,
  input  logic [cw_bits(DATA_W)-1:0] cw_i,
  output logic                       valid_o,
  output logic [DATA_W-1:0]          data_o,
  output ecc_flags_t                 flags_o
);

  localparam int P  = pos_bits(DATA_W);
  localparam int HW = DATA_W + P;

  logic [P-1:0]      syn;
  logic              ovr;
  ecc_flags_t        fl;
  logic              fix_en;
  logic [DATA_W-1:0] dat;

  always_comb begin
    syn = '0;
    for (int p = 1; p <= HW; p++) begin
      if (cw_i[p]) syn = syn ^ P'(p);
    end
    ovr    = ^cw_i;
    fl     = '0;
    fix_en = 1'b0;
    if (ovr) begin
      if (syn == '0) begin
        fl.corrected = 1'b1;            // parity bit alone was hit
      end else if (int'(syn) <= HW) begin
        fl.corrected = 1'b1;
        fix_en       = 1'b1;
      end else begin
        fl.uncorrectable = 1'b1;        // points outside the codeword
      end
    end else if (syn != '0) begin
      fl.uncorrectable = 1'b1;          // two bits flipped
    end
    for (int i = 0; i < DATA_W; i++) begin
      dat[i] = cw_i[data_slot(i)] ^ (fix_en && (int'(syn) == data_slot(i)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o  <= dat;
        flags_o <= fl;
      end else begin
        flags_o <= '0;
      end
    end
  end

endmodule

// File: rtl/hilv_shuffle.sv
module hilv_shuffle #(
  parameter int W       = 22,
  parameter int N       = 16,
  parameter bit INVERSE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  output logic [W-1:0] out_word
);

  localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam int TOT   = N * W;

  logic [W-1:0]     fill [N];
  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] rd_cnt;
  logic             draining;
  logic             last;
  logic [TOT-1:0]   blk_flat;
  logic [TOT-1:0]   drain_flat;
  wire  [TOT-1:0]   perm_flat;

  assign last = in_valid && (wr_cnt == CNT_W'(N - 1));

  // fill bank: plain indexed writes, no reset
  always_ff @(posedge clk) begin
    if (in_valid) fill[wr_cnt] <= in_word;
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      blk_flat[j*W +: W] = (j == N - 1) ? in_word : fill[j];
    end
  end

  // serial index n = word*W + bit; forward sends codeword n%N bit n/N
  for (genvar w = 0; w < N; w++) begin : g_word
    for (genvar b = 0; b < W; b++) begin : g_bit
      localparam int NI = INVERSE ? (b * N + w) : (w * W + b);
      localparam int SW = INVERSE ? (NI / W) : (NI % N);
      localparam int SB = INVERSE ? (NI % W) : (NI / N);
      assign perm_flat[w*W+b] = blk_flat[SW*W+SB];
    end
  end

  always_ff @(posedge clk) begin
    if (last) drain_flat <= perm_flat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt    <= '0;
      rd_cnt    <= '0;
      draining  <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      if (in_valid) wr_cnt <= last ? '0 : wr_cnt + 1'b1;
      out_valid <= draining;
      if (draining) begin
        out_word <= drain_flat[rd_cnt*W +: W];
        rd_cnt   <= rd_cnt + 1'b1;
        if (rd_cnt == CNT_W'(N - 1)) draining <= 1'b0;
      end
      if (last) begin
        draining <= 1'b1;
        rd_cnt   <= '0;
      end
    end
  end

endmodule

// File: rtl/hilv_codec.sv
module hilv_codec
  import hilv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLOCK  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enc_valid_i,
  input  logic [DATA_W-1:0]          enc_data_i,
  output logic                       line_tx_valid_o,
  output logic [cw_bits(DATA_W)-1:0] line_tx_word_o,
  input  logic                       line_rx_valid_i,
  input  logic [cw_bits(DATA_W)-1:0] line_rx_word_i,
  output logic                       dec_valid_o,
  output logic [DATA_W-1:0]          dec_data_o,
  output logic                       dec_corrected_o,
  output logic                       dec_uncorrectable_o
);

  localparam int CW = cw_bits(DATA_W);

  logic [CW-1:0] enc_cw;
  logic          rx_cw_valid;
  logic [CW-1:0] rx_cw;
  ecc_flags_t    dec_flags;

  hilv_encoder #(.DATA_W(DATA_W)) u_enc (
    .data_i (enc_data_i),
    .cw_o   (enc_cw)
  );

  hilv_shuffle #(.W(CW), .N(BLOCK), .INVERSE(1'b0)) u_tx_ilv (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (enc_valid_i),
    .in_word   (enc_cw),
    .out_valid (line_tx_valid_o),
    .out_word  (line_tx_word_o)
  );

  hilv_shuffle #(.W(CW), .N(BLOCK), .INVERSE(1'b1)) u_rx_dilv (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (line_rx_valid_i),
    .in_word   (line_rx_word_i),
    .out_valid (rx_cw_valid),
    .out_word  (rx_cw)
  );

  hilv_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .valid_i (rx_cw_valid),
    .cw_i    (rx_cw),
    .valid_o (dec_valid_o),
    .data_o  (dec_data_o),
    .flags_o (dec_flags)
  );

  assign dec_corrected_o     = dec_flags.corrected;
  assign dec_uncorrectable_o = dec_flags.uncorrectable;

endmodule

// File: rtl/hilv_codec_chk.sv
module hilv_codec_chk #(
  parameter int BLOCK = 16
) (
  input logic clk,
  input logic rst,
  input logic tx_valid,
  input logic dec_valid,
  input logic dec_corr,
  input logic dec_unc
);

  logic [15:0] tx_run;
  logic [15:0] dec_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_run  <= '0;
      dec_run <= '0;
    end else begin
      tx_run  <= tx_valid  ? tx_run + 1'b1  : '0;
      dec_run <= dec_valid ? dec_run + 1'b1 : '0;
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!tx_valid && !dec_valid));

  assert_tx_whole_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_valid) |-> (tx_run != 0 && (int'(tx_run) % BLOCK) == 0));

  assert_dec_whole_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(dec_valid) |-> (dec_run != 0 && (int'(dec_run) % BLOCK) == 0));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !(dec_corr && dec_unc));

  assert_flags_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_corr && !dec_unc));

endmodule

bind hilv_codec hilv_codec_chk #(.BLOCK(BLOCK)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_valid  (line_tx_valid_o),
  .dec_valid (dec_valid_o),
  .dec_corr  (dec_corrected_o),
  .dec_unc   (dec_uncorrectable_o)
);

// File: tb/hilv_codec_test.sv
module hilv_codec_test;

  localparam int DW   = 16;
  localparam int CW   = 22;
  localparam int NB   = 16;
  localparam int NBLK = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          enc_valid = 1'b0;
  logic [DW-1:0] enc_data  = '0;
  logic          tx_valid;
  logic [CW-1:0] tx_word;
  logic          rx_valid;
  logic [CW-1:0] rx_word;
  logic          dec_valid, dec_corr, dec_unc;
  logic [DW-1:0] dec_data;

  int total = 0;
  int bad   = 0;

  // per-block error injection on the looped-back line
  int cfg_start [NBLK];
  int cfg_len   [NBLK];
  int cfg_a     [NBLK];
  int cfg_b     [NBLK];
  bit cfg_exact [NBLK];
  int tx_blk, tx_idx;

  function automatic logic [CW-1:0] err_mask(input int blk, input int w);
    logic [CW-1:0] m;
    m = '0;
    if (blk < NBLK) begin
      for (int b = 0; b < CW; b++) begin
        int n;
        n = w * CW + b;
        if (n >= cfg_start[blk] && n < cfg_start[blk] + cfg_len[blk]) m[b] = 1'b1;
        if (n == cfg_a[blk] || n == cfg_b[blk]) m[b] = 1'b1;
      end
    end
    return m;
  endfunction

  assign rx_valid = tx_valid;
  assign rx_word  = tx_word ^ err_mask(tx_blk, tx_idx);

  hilv_codec uut (
    .clk                 (clk),
    .rst                 (rst),
    .enc_valid_i         (enc_valid),
    .enc_data_i          (enc_data),
    .line_tx_valid_o     (tx_valid),
    .line_tx_word_o      (tx_word),
    .line_rx_valid_i     (rx_valid),
    .line_rx_word_i      (rx_word),
    .dec_valid_o         (dec_valid),
    .dec_data_o          (dec_data),
    .dec_corrected_o     (dec_corr),
    .dec_uncorrectable_o (dec_unc)
  );

  always @(posedge clk) begin
    if (rst) begin
      tx_blk <= 0;
      tx_idx <= 0;
    end else if (tx_valid) begin
      if (tx_idx == NB - 1) begin
        tx_idx <= 0;
        tx_blk <= tx_blk + 1;
      end else begin
        tx_idx <= tx_idx + 1;
      end
    end
  end

  // ---------------- reference model (R2 layout, R3 ordering) ----------------
  function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[di];
        di++;
      end
    end
    for (int q = 1; q < CW; q = q * 2) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p < CW; p++) if ((p & q) != 0 && p != q) par ^= c[p];
      c[q] = par;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic void ref_dec(input logic [CW-1:0] c_in, output logic [DW-1:0] d,
                                  output logic corr, output logic unc, output logic ponly);
    logic [CW-1:0] c;
    int syn, di;
    logic ov;
    c = c_in;
    syn = 0;
    for (int p = 1; p < CW; p++) if (c[p]) syn ^= p;
    ov = ^c;
    corr = 1'b0; unc = 1'b0; ponly = 1'b0;
    if (ov) begin
      if (syn == 0) begin corr = 1'b1; ponly = 1'b1; end
      else if (syn < CW) begin corr = 1'b1; c[syn] = ~c[syn]; end
      else unc = 1'b1;
    end else if (syn != 0) unc = 1'b1;
    di = 0;
    for (int p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[di] = c[p];
        di++;
      end
    end
  endfunction

  int            cyc;
  logic [DW-1:0] in_q[$];
  logic [CW-1:0] rx_q[$];
  int            txdue_q[$];
  logic [CW-1:0] txw_q[$];
  int            txblk_q[$];
  int            ddue_q[$];
  logic [DW-1:0] dd_q[$];
  logic          dc_q[$];
  logic          du_q[$];
  logic          dp_q[$];
  logic [DW-1:0] sent_q[$];
  int            enc_blk;
  int            dec_cnt;
  logic [CW-1:0] cws  [NB];
  logic [CW-1:0] lw   [NB];

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; enc_blk = 0;
      in_q.delete(); rx_q.delete(); sent_q.delete();
      txdue_q.delete(); txw_q.delete(); txblk_q.delete();
      ddue_q.delete(); dd_q.delete(); dc_q.delete(); du_q.delete(); dp_q.delete();
    end else begin
      cyc++;
      if (enc_valid) begin
        in_q.push_back(enc_data);
        sent_q.push_back(enc_data);
        if (in_q.size() == NB) begin
          for (int j = 0; j < NB; j++) cws[j] = ref_enc(in_q[j]);
          for (int w = 0; w < NB; w++) begin
            for (int b = 0; b < CW; b++) begin
              int n;
              n = w * CW + b;
              lw[w][b] = cws[n % NB][n / NB];
            end
            txdue_q.push_back(cyc + 1 + w);
            txw_q.push_back(lw[w]);
            txblk_q.push_back(enc_blk);
          end
          enc_blk++;
          in_q.delete();
        end
      end
      if (rx_valid) begin
        rx_q.push_back(rx_word);
        if (rx_q.size() == NB) begin
          for (int j = 0; j < NB; j++) begin
            logic [CW-1:0] c;
            logic [DW-1:0] d;
            logic fc, fu, fp;
            for (int k = 0; k < CW; k++) begin
              int n;
              n = k * NB + j;
              c[k] = rx_q[n / CW][n % CW];
            end
            ref_dec(c, d, fc, fu, fp);
            ddue_q.push_back(cyc + 2 + j);
            dd_q.push_back(d);
            dc_q.push_back(fc);
            du_q.push_back(fu);
            dp_q.push_back(fp);
          end
          rx_q.delete();
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // compare on falling edges, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (txdue_q.size() != 0 && txdue_q[0] == cyc) begin
        chk(tx_valid === 1'b1, "R4", "tx valid due", 32'(tx_valid), 1);
        // R2 codeword layout seen through the R3 ordering; block 7 has input gaps (R5)
        chk(tx_word === txw_q[0], (txblk_q[0] == 7) ? "R5" : "R3", "tx word",
            32'(tx_word), 32'(txw_q[0]));
        void'(txdue_q.pop_front()); void'(txw_q.pop_front()); void'(txblk_q.pop_front());
      end else begin
        chk(tx_valid === 1'b0, "R4", "tx valid idle", 32'(tx_valid), 0);
      end

      if (ddue_q.size() != 0 && ddue_q[0] == cyc) begin
        string tag;
        logic [DW-1:0] orig;
        int blk;
        tag = du_q[0] ? "R9" : (dp_q[0] ? "R8" : (dc_q[0] ? "R7" : "R12"));
        chk(dec_valid === 1'b1, "R6", "dec valid due", 32'(dec_valid), 1);
        chk(dec_data === dd_q[0], tag, "dec data", 32'(dec_data), 32'(dd_q[0]));
        chk(dec_corr === dc_q[0], tag, "corrected flag", 32'(dec_corr), 32'(dc_q[0]));
        chk(dec_unc === du_q[0], tag, "uncorrectable flag", 32'(dec_unc), 32'(du_q[0]));
        orig = sent_q.pop_front();
        blk  = dec_cnt / NB;
        if (blk < NBLK && cfg_exact[blk])
          chk(dec_data === orig && dec_unc === 1'b0, "R10", "end-to-end data",
              32'(dec_data), 32'(orig));
        else
          chk(dec_unc === 1'b1 || dec_data === orig, "R11", "end-to-end data or flag",
              32'(dec_data), 32'(orig));
        dec_cnt++;
        void'(ddue_q.pop_front()); void'(dd_q.pop_front()); void'(dc_q.pop_front());
        void'(du_q.pop_front()); void'(dp_q.pop_front());
      end else begin
        chk(dec_valid === 1'b0, "R6", "dec valid idle", 32'(dec_valid), 0);
        chk(dec_corr === 1'b0 && dec_unc === 1'b0, "R12", "flags while idle",
            {30'd0, dec_corr, dec_unc}, 0);
      end
    end
  end

  function automatic logic [DW-1:0] pattern(input int blk, input int i);
    case (blk)
      0:       return DW'(i);
      1:       return (i % 2 == 1) ? 16'h5555 : 16'hAAAA;
      10:      return '1;
      11:      return '0;
      default: return DW'(blk * 4099 + i * 40503 + 7);
    endcase
  endfunction

  task automatic send(input logic [DW-1:0] d);
    enc_valid = 1'b1;
    enc_data  = d;
    @(negedge clk);
    enc_valid = 1'b0;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R4 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : stim
    dec_cnt = 0;
    for (int k = 0; k < NBLK; k++) begin
      cfg_start[k] = 0; cfg_len[k] = 0; cfg_a[k] = -1; cfg_b[k] = -1; cfg_exact[k] = 1'b1;
    end
    cfg_start[2] = 100; cfg_len[2] = 11;                      // R10 burst of 11
    cfg_a[3]     = 3;                                          // R8 codeword 3 bit 0
    cfg_start[4] = 200; cfg_len[4] = 31; cfg_exact[4] = 1'b0;  // R11 burst of 31
    cfg_start[5] = 0;   cfg_len[5] = 17; cfg_exact[5] = 1'b0;  // double in codeword 0
    cfg_a[6] = 50; cfg_b[6] = 82; cfg_exact[6] = 1'b0;         // R9 codeword 2 bits 3,5
    cfg_start[8] = 341; cfg_len[8] = 11;                       // burst at block end
    cfg_start[9] = 0;   cfg_len[9] = 12;

    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_valid === 1'b0 && dec_valid === 1'b0, "R1", "valids in reset",
        {30'd0, tx_valid, dec_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_valid === 1'b0 && dec_valid === 1'b0, "R1", "valids after reset",
        {30'd0, tx_valid, dec_valid}, 0);

    for (int blk = 0; blk < NBLK; blk++) begin
      for (int i = 0; i < NB; i++) begin
        send(pattern(blk, i));
        if (blk == 7 && (i % 3) != 2) repeat (1 + i % 2) @(negedge clk);  // R5 gaps
      end
      if (blk == 1) repeat (5) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    chk(txdue_q.size() == 0 && ddue_q.size() == 0, "R6", "all outputs delivered",
        32'(txdue_q.size() + ddue_q.size()), 0);
    chk(dec_cnt == NBLK * NB, "R10", "decoded word count", 32'(dec_cnt), 32'(NBLK * NB));
    summary();
    $finish;
  end

endmodule